// File: doc/BRIEF.md
# Programmable One-Shot Pulse Generator

This block turns a rising edge on an asynchronous trigger line into a single output pulse. The output pulse starts a fixed number of clock cycles after the edge is seen. Its width is picked by a 6-bit width selector, in steps of a parameterised base increment. An inverted copy of the pulse is driven on a second pin. All timing is counted in cycles of the system clock.

The generator cannot be retriggered. Once it has accepted an edge, it passes through three phases: a lead-in delay, the pulse itself, and a recovery holdoff. It ignores every trigger edge until it is idle again, and those edges are dropped, not saved for later. A synchronous, active-high reset returns it to idle with the output low, so it can accept a trigger on the next cycles without first waiting out a stale pulse.

There is no data stream in this block. The trigger, the selector, the reset and both outputs are plain control pins, with no valid/ready handshake.

Top module: `pulse_oneshot`

## Requirements
- R1: While `rst` is high on a rising edge, the next cycle shows `pulse_out` = 0 and `pulse_out_n` = 1, even in the middle of a pulse. A trigger raised right after reset is released is served with the normal latency and width.
- R2: Only a low-to-high transition of `trig_in` starts a pulse. Holding `trig_in` high after a pulse produces no further pulse.
- R3: `trig_in` passes through a two-flop synchroniser and one edge-detect register. As a result, `pulse_out` first reads high after the (DELAY_CYC+3)-th rising clock edge. The first of those edges is the one that samples `trig_in` high.
- R4: The pulse stays high for exactly (width_sel+1)*BASE_INC cycles. For example, selector 0 gives BASE_INC cycles and selector 63 gives 64*BASE_INC cycles. The width therefore never decreases as the selector value increases.
- R5: `width_sel` is captured in the cycle the trigger edge is accepted. Changing it during the delay or the pulse does not alter the pulse in progress.
- R6: Trigger edges that occur during the delay or the pulse do not change the width and do not cause a later pulse.
- R7: After the pulse falls, the block stays in recovery for RECOVER_CYC cycles. Count the rising edges after the edge on which the output fell. If `trig_in` is first sampled high on edge k, the trigger is dropped when k <= RECOVER_CYC-2 and accepted when k = RECOVER_CYC-1.
- R8: `pulse_out_n` is the inverse of `pulse_out` in every cycle outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous trigger line |
| width_sel | input | 6 | Pulse width selector, captured at acceptance |
| pulse_out | output | 1 | One-shot pulse |
| pulse_out_n | output | 1 | Inverse of `pulse_out` |

## Verification
The end of recovery and the arrival of a new trigger edge can fall in the same cycle. If that edge reaches the detector on the very edge where the recovery count expires, it must be dropped. If it arrives one cycle later, it must be taken with the normal latency. The bench provokes both cases. It lowers the trigger on the sample where the output fell, then raises it RECOVER_CYC-3 samples later in one run and RECOVER_CYC-2 samples later in another. It judges the first run by a long window with no pulse, and the second by the measured latency.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DELAY   = 2'd1,
    ST_PULSE   = 2'd2,
    ST_RECOVER = 2'd3
  } os_state_e;
endpackage

// File: rtl/os_trig_edge.sv
module os_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_async,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= trig_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], trig_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/os_width_map.sv
module os_width_map #(
  parameter int ADDR_W   = 6,
  parameter int BASE_INC = 2,
  parameter int CNT_W    = 8
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [CNT_W-1:0]  len_m1
);
  always_comb begin
    len_m1 = CNT_W'((int'(sel) + 1) * BASE_INC - 1);
  end
endmodule

// File: rtl/os_seq_fsm.sv
module os_seq_fsm
  import oneshot_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DELAY_CYC   = 3,
  parameter int RECOVER_CYC = 5,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [ADDR_W-1:0] sel_in,
  input  logic [CNT_W-1:0]  len_m1,
  output logic [ADDR_W-1:0] sel_q,
  output os_state_e         state
);
  localparam logic [CNT_W-1:0] DLY_M1 = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] REC_M1 = CNT_W'(RECOVER_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rise) begin
            state <= ST_DELAY;
            cnt_q <= DLY_M1;
            sel_q <= sel_in;
          end
        end
        ST_DELAY: begin
          if (cnt_done) begin
            state <= ST_PULSE;
            cnt_q <= len_m1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_done) begin
            state <= ST_RECOVER;
            cnt_q <= REC_M1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RECOVER: begin
          if (cnt_done) state <= ST_IDLE;
          else          cnt_q <= cnt_q - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
  import oneshot_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BASE_INC    = 2,
  parameter int DELAY_CYC   = 3,
  parameter int RECOVER_CYC = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_in,
  input  logic [ADDR_W-1:0] width_sel,
  output logic              pulse_out,
  output logic              pulse_out_n
);
  localparam int MAX_LEN = (2 ** ADDR_W) * BASE_INC;
  localparam int MAX_T1  = (MAX_LEN > DELAY_CYC) ? MAX_LEN : DELAY_CYC;
  localparam int MAX_ALL = (MAX_T1 > RECOVER_CYC) ? MAX_T1 : RECOVER_CYC;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  logic              rise;
  logic [ADDR_W-1:0] sel_q;
  logic [CNT_W-1:0]  len_m1;
  os_state_e         state;

  os_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .trig_async(trig_in),
    .rise      (rise)
  );

  os_width_map #(.ADDR_W(ADDR_W), .BASE_INC(BASE_INC), .CNT_W(CNT_W)) u_map (
    .sel   (sel_q),
    .len_m1(len_m1)
  );

  os_seq_fsm #(
    .ADDR_W(ADDR_W), .DELAY_CYC(DELAY_CYC),
    .RECOVER_CYC(RECOVER_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .rise  (rise),
    .sel_in(width_sel),
    .len_m1(len_m1),
    .sel_q (sel_q),
    .state (state)
  );

  assign pulse_out   = (state == ST_PULSE);
  assign pulse_out_n = ~pulse_out;
endmodule

// File: rtl/os_checker.sv
module os_checker #(
  parameter int ADDR_W      = 6,
  parameter int BASE_INC    = 2,
  parameter int DELAY_CYC   = 3,
  parameter int RECOVER_CYC = 5
) (
  input logic clk,
  input logic rst,
  input logic pulse_out,
  input logic pulse_out_n
);
  localparam int MAX_LEN = (2 ** ADDR_W) * BASE_INC;
  localparam int GAP_MIN = DELAY_CYC + RECOVER_CYC + 1;
  localparam int CW      = $clog2(MAX_LEN + GAP_MIN + 4) + 1;

  logic [CW-1:0] lo_cnt;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '1;
      hi_cnt <= '0;
    end else if (pulse_out) begin
      lo_cnt <= '0;
      hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  AST_RESET_QUIETS: assert property (@(posedge clk) rst |=> !pulse_out); // R1

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    pulse_out_n != pulse_out); // R8

  AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_out) && !$past(rst)) |->
      (hi_cnt >= CW'(BASE_INC) && hi_cnt <= CW'(MAX_LEN))); // R4

  AST_WIDTH_STEP: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_out) && !$past(rst)) |->
      ((int'(hi_cnt) % BASE_INC) == 0)); // R4

  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> (lo_cnt >= CW'(GAP_MIN))); // R7
endmodule

bind pulse_oneshot os_checker #(
  .ADDR_W(ADDR_W), .BASE_INC(BASE_INC),
  .DELAY_CYC(DELAY_CYC), .RECOVER_CYC(RECOVER_CYC)
) u_os_checker (
  .clk        (clk),
  .rst        (rst),
  .pulse_out  (pulse_out),
  .pulse_out_n(pulse_out_n)
);

// File: tb/pulse_oneshot_test.sv
`timescale 1ns/1ps
module pulse_oneshot_test;
  localparam int AW  = 6;
  localparam int BI  = 2;
  localparam int DC  = 3;
  localparam int RC  = 5;
  localparam int LAT = DC + 3;
  localparam int LIM = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig_in = 1'b0;
  logic [AW-1:0] width_sel = '0;
  logic          pulse_out;
  logic          pulse_out_n;

  int n_chk = 0;
  int n_fail = 0;
  int compl_bad = 0;

  always #2.5 clk = ~clk;

  pulse_oneshot #(.ADDR_W(AW), .BASE_INC(BI), .DELAY_CYC(DC), .RECOVER_CYC(RC)) uut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .width_sel(width_sel),
    .pulse_out(pulse_out), .pulse_out_n(pulse_out_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Samples at falling edges; returns on the first low sample after the pulse.
  task automatic wait_pulse(input int new_sel, input bit toggle,
                            output int lat, output int wid);
    int k = 0;
    lat = -1;
    wid = 0;
    while (k < LIM) begin
      @(negedge clk);
      k++;
      if (pulse_out_n == pulse_out) compl_bad++;
      if (pulse_out) begin
        if (lat < 0) begin
          lat = k;
          if (new_sel >= 0) width_sel = AW'(new_sel);
        end
        wid++;
        if (toggle) trig_in = ~trig_in;
      end else if (lat >= 0) begin
        break;
      end else if (toggle) begin
        trig_in = ~trig_in;
      end
    end
    if (toggle) trig_in = 1'b0;
  endtask

  task automatic fire(input int sel, input int new_sel, input bit toggle,
                      output int lat, output int wid);
    @(negedge clk);
    width_sel = AW'(sel);
    trig_in   = 1'b1;
    wait_pulse(new_sel, toggle, lat, wid);
  endtask

  task automatic watch_quiet(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pulse_out) highs++;
    end
  endtask

  task automatic settle();
    trig_in = 1'b0;
    repeat (RC + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0, "R1", "out during reset", pulse_out, 0);
    check(pulse_out_n == 1'b1, "R1", "out_n during reset", pulse_out_n, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_widths();
    int sels[5] = '{0, 1, 5, 31, 63};
    int lat, wid;
    foreach (sels[i]) begin
      fire(sels[i], -1, 1'b0, lat, wid);
      check(lat == LAT, "R3", "latency", lat, LAT);
      check(wid == (sels[i] + 1) * BI, "R4", "width", wid, (sels[i] + 1) * BI);
      settle();
    end
  endtask

  task automatic t_level_hold();
    int lat, wid, highs;
    fire(2, -1, 1'b0, lat, wid);
    check(wid == 3 * BI, "R4", "width before hold", wid, 3 * BI);
    watch_quiet(60, highs);
    check(highs == 0, "R2", "pulses while held high", highs, 0);
    settle();
  endtask

  task automatic t_sel_change();
    int lat, wid;
    fire(10, 1, 1'b0, lat, wid);
    check(wid == 11 * BI, "R5", "width after mid change", wid, 11 * BI);
    settle();
  endtask

  task automatic t_ignore();
    int lat, wid, highs;
    fire(4, -1, 1'b1, lat, wid);
    check(lat == LAT, "R6", "latency under toggling", lat, LAT);
    check(wid == 5 * BI, "R6", "width under toggling", wid, 5 * BI);
    watch_quiet(60, highs);
    check(highs == 0, "R6", "queued pulse", highs, 0);
    settle();
  endtask

  task automatic t_recovery();
    int lat, wid, highs;
    fire(0, -1, 1'b0, lat, wid);
    trig_in = 1'b0;
    repeat (RC - 3) @(negedge clk);
    trig_in = 1'b1;
    watch_quiet(50, highs);
    check(highs == 0, "R7", "edge at recovery end", highs, 0);
    settle();
    fire(0, -1, 1'b0, lat, wid);
    trig_in = 1'b0;
    repeat (RC - 2) @(negedge clk);
    trig_in = 1'b1;
    wait_pulse(-1, 1'b0, lat, wid);
    check(lat == LAT, "R7", "edge after recovery latency", lat, LAT);
    check(wid == BI, "R7", "edge after recovery width", wid, BI);
    settle();
  endtask

  task automatic t_reset_mid();
    int lat, wid;
    @(negedge clk);
    width_sel = 6'd63;
    trig_in   = 1'b1;
    repeat (LAT + 3) @(negedge clk);
    check(pulse_out == 1'b1, "R3", "pulse active before reset", pulse_out, 1);
    rst = 1'b1;
    @(negedge clk);
    check(pulse_out == 1'b0, "R1", "out after mid reset", pulse_out, 0);
    check(pulse_out_n == 1'b1, "R1", "out_n after mid reset", pulse_out_n, 1);
    rst = 1'b0;
    trig_in = 1'b0;
    fire(0, -1, 1'b0, lat, wid);
    check(lat == LAT, "R1", "latency right after reset", lat, LAT);
    check(wid == BI, "R1", "width right after reset", wid, BI);
    settle();
  endtask

  initial begin
    t_reset();
    t_widths();
    t_level_hold();
    t_sel_change();
    t_ignore();
    t_recovery();
    t_reset_mid();
    check(compl_bad == 0, "R8", "complement mismatches", compl_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule